// File: doc/BRIEF.md
# Burst Read Responder

This block is the answering side of a small request/strobe/done memory handshake. A master asks for a block by pulsing a request line for one cycle while it drives a byte address. After a fixed, configurable number of quiet cycles, the responder streams the whole block from its internal word memory. Each word it sends is marked with a data strobe. When the last word has gone out, it raises a done pulse for one cycle and returns the request's address on an echo bus.

The same burst window also serves as a write path. In any data cycle of a burst, the master may raise its own strobe with a word on its data bus. That word is stored at the location being read in that cycle. The response for that cycle still shows the word that was there before the store.

Requests are accepted only when the responder is idle. A request that arrives at any other time is dropped and raises a sticky overrun flag. Reset rebuilds the memory so that every word holds its own index, which makes every read beat predictable.

Top module: `burst_read_responder`

## Requirements
- R1: While reset (synchronous, active low) is applied, and in the first cycle after it, the response strobe and the done pulse are low, the response data and echo buses are zero, and the overrun flag is clear.
- R2: A request is taken when `req_valid` is high in a cycle where the responder is idle. The byte address on `req_addr` in that same cycle is the one captured.
- R3: If the request is sampled in cycle T, the first word appears with `rsp_sync` high in cycle T+LAT+1. That leaves LAT quiet cycles, and LAT must be at least 1.
- R4: A burst holds `rsp_sync` high for exactly BEATS = BLOCK_BYTES/(DW/8) consecutive cycles, which is 512 words by default. Beat k carries memory word (start + k) mod MEM_WORDS. Whenever `rsp_sync` is low, `rsp_data` is zero.
- R5: `rsp_ready` is high for exactly one cycle: the cycle directly after the last beat, in which `rsp_sync` is low. In that cycle `rsp_addr` carries the captured request address unchanged, low bits included. In every other cycle `rsp_addr` is zero.
- R6: On reset, every memory word is set to its own index, zero-extended to DW bits. This also undoes earlier stores.
- R7: Word indices wrap modulo MEM_WORDS, which must be a power of two. A burst that starts near the top of memory continues from word 0.
- R8: In a beat cycle where `mst_sync` is high, `mst_data` is stored into the word that beat reads. The beat itself still returns the word's previous content.
- R9: A request that arrives while the responder is not idle has no effect on the burst in progress and starts no burst of its own. It sets `overrun`, which stays high until reset.
- R10: The start word is the byte address divided by DW/8: the two low address bits are ignored for 32-bit data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Single-cycle request pulse |
| req_addr | input | AW | Byte address of the request |
| mst_sync | input | 1 | Master write strobe, honoured in beat cycles |
| mst_data | input | DW | Master write word |
| rsp_sync | output | 1 | Response data strobe |
| rsp_data | output | DW | Response word, zero outside beats |
| rsp_ready | output | 1 | One-cycle completion pulse |
| rsp_addr | output | AW | Echoed request address during completion |
| overrun | output | 1 | Sticky flag: request seen while busy |

## Verification
The bench aims at the following corner cases, and what a faulty design would do in each:

- **Start latency.** Being one cycle off shifts every beat; the bench times the first beat to the exact cycle.
- **Burst length and completion.** Miscounting the burst, or closing it a cycle late or early, shows up as a short or long burst, or as a done pulse that overlaps the strobe.
- **Wrap and address masking.** A burst starting three-quarters up the memory exposes a missing wrap as wrong data after the top word. A byte address with low bits set exposes any use of those bits in the index.
- **Store timing.** A store that takes effect early returns the new word during the write burst instead of the old one. A store that is lost shows up on the read-back.
- **Request while busy.** A second request pulsed mid-burst would either corrupt the running burst or start a stray one.
- **Reset.** A reset that fails to rebuild the memory returns stale written data afterwards.

// File: rtl/brr_pkg.sv
package brr_pkg;

    // Phases of one request, in the order they occur.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_BURST = 2'd2,
        ST_DONE  = 2'd3
    } brr_state_e;

endpackage

// File: rtl/brr_store.sv
module brr_store #(
    parameter int DW    = 32,
    parameter int WORDS = 1024,
    localparam int IW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] mem_q [WORDS];

    // Asynchronous read: the beat shows the content held before this cycle's store.
    assign rd_data = mem_q[idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                mem_q[i] <= DW'(i);
            end
        end else if (wr_en) begin
            mem_q[idx] <= wr_data;
        end
    end

endmodule

// File: rtl/brr_addr_map.sv
module brr_addr_map #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int WORDS = 1024,
    parameter int BW    = 9,
    localparam int IW   = $clog2(WORDS),
    localparam int SH   = $clog2(DW / 8)
) (
    input  logic [AW-1:0] byte_addr,
    input  logic [IW-1:0] base_idx,
    input  logic [BW-1:0] beat,
    output logic [IW-1:0] start_idx,
    output logic [IW-1:0] word_idx
);

    logic [IW-1:0] beat_ext;

    always_comb begin
        start_idx = byte_addr[SH +: IW];
        beat_ext  = IW'(beat);
        word_idx  = base_idx + beat_ext;
    end

endmodule

// File: rtl/brr_sequencer.sv
module brr_sequencer
    import brr_pkg::*;
#(
    parameter int AW    = 32,
    parameter int IW    = 10,
    parameter int BEATS = 512,
    parameter int LAT   = 2,
    localparam int BW   = (BEATS > 1) ? $clog2(BEATS) : 1,
    localparam int CW   = $clog2(LAT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic [IW-1:0] start_idx,
    output logic          burst_on,
    output logic          done_on,
    output logic [IW-1:0] base_idx,
    output logic [BW-1:0] beat,
    output logic [AW-1:0] echo_addr,
    output logic          ovr
);

    typedef struct packed {
        brr_state_e    st;
        logic [CW-1:0] wait_cnt;
        logic [BW-1:0] beat;
        logic [IW-1:0] base;
        logic [AW-1:0] addr;
        logic          ovr;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (req_valid && seq_q.st != ST_IDLE) begin
            seq_d.ovr = 1'b1;
        end
        unique case (seq_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    seq_d.st       = ST_WAIT;
                    seq_d.wait_cnt = CW'(LAT - 1);
                    seq_d.base     = start_idx;
                    seq_d.addr     = req_addr;
                end
            end
            ST_WAIT: begin
                if (seq_q.wait_cnt == '0) begin
                    seq_d.st   = ST_BURST;
                    seq_d.beat = '0;
                end else begin
                    seq_d.wait_cnt = seq_q.wait_cnt - 1'b1;
                end
            end
            ST_BURST: begin
                if (seq_q.beat == BW'(BEATS - 1)) begin
                    seq_d.st = ST_DONE;
                end else begin
                    seq_d.beat = seq_q.beat + 1'b1;
                end
            end
            ST_DONE: begin
                seq_d.st = ST_IDLE;
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign burst_on  = (seq_q.st == ST_BURST);
    assign done_on   = (seq_q.st == ST_DONE);
    assign base_idx  = seq_q.base;
    assign beat      = seq_q.beat;
    assign echo_addr = (seq_q.st == ST_DONE) ? seq_q.addr : '0;
    assign ovr       = seq_q.ovr;

    // R2: an idle request moves to the wait phase with its address captured
    p_accept_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_IDLE && req_valid) |=> (seq_q.st == ST_WAIT && seq_q.addr == $past(req_addr)));

    // R5: completion only directly after a burst
    p_done_after_burst_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_DONE) |-> ($past(seq_q.st) == ST_BURST));

    // R9: overrun flag never clears outside reset
    p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.ovr |=> seq_q.ovr);

    // R3: the wait counter never exceeds its load value
    p_wait_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_WAIT) |-> (seq_q.wait_cnt <= CW'(LAT - 1)));

endmodule

// File: rtl/burst_read_responder.sv
module burst_read_responder #(
    parameter int DW          = 32,
    parameter int AW          = 32,
    parameter int BLOCK_BYTES = 2048,
    parameter int MEM_WORDS   = 1024,
    parameter int LAT         = 2,
    localparam int BEATS      = BLOCK_BYTES / (DW / 8),
    localparam int IW         = $clog2(MEM_WORDS),
    localparam int BW         = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic          mst_sync,
    input  logic [DW-1:0] mst_data,
    output logic          rsp_sync,
    output logic [DW-1:0] rsp_data,
    output logic          rsp_ready,
    output logic [AW-1:0] rsp_addr,
    output logic          overrun
);

    logic [IW-1:0] start_idx;
    logic [IW-1:0] word_idx;
    logic [IW-1:0] base_idx;
    logic [BW-1:0] beat;
    logic [DW-1:0] rd_word;
    logic          burst_on;
    logic          done_on;

    brr_addr_map #(
        .AW(AW), .DW(DW), .WORDS(MEM_WORDS), .BW(BW)
    ) u_map (
        .byte_addr (req_addr),
        .base_idx  (base_idx),
        .beat      (beat),
        .start_idx (start_idx),
        .word_idx  (word_idx)
    );

    brr_sequencer #(
        .AW(AW), .IW(IW), .BEATS(BEATS), .LAT(LAT)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .start_idx (start_idx),
        .burst_on  (burst_on),
        .done_on   (done_on),
        .base_idx  (base_idx),
        .beat      (beat),
        .echo_addr (rsp_addr),
        .ovr       (overrun)
    );

    brr_store #(
        .DW(DW), .WORDS(MEM_WORDS)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (burst_on && mst_sync),
        .idx     (word_idx),
        .wr_data (mst_data),
        .rd_data (rd_word)
    );

    assign rsp_sync  = burst_on;
    assign rsp_data  = burst_on ? rd_word : '0;
    assign rsp_ready = done_on;

    // R5: completion pulse lasts one cycle
    p_ready_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |=> !rsp_ready);

    // R5: completion follows a falling data strobe
    p_ready_after_sync_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |-> (!rsp_sync && $past(rsp_sync)));

    // R5: echo bus idles at zero
    p_addr_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_ready |-> (rsp_addr == '0));

    // R4: data bus idles at zero
    p_data_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_sync |-> (rsp_data == '0));

    // R9: a request during a burst raises overrun
    p_busy_req_ovr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rsp_sync) |=> overrun);

endmodule

// File: tb/burst_read_responder_test.sv
module burst_read_responder_test;

    localparam int DW    = 32;
    localparam int AW    = 32;
    localparam int BLK   = 2048;
    localparam int WORDS = 1024;
    localparam int LAT   = 2;
    localparam int BEATS = BLK / (DW / 8);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          mst_sync = 1'b0;
    logic [DW-1:0] mst_data = '0;
    logic          rsp_sync;
    logic [DW-1:0] rsp_data;
    logic          rsp_ready;
    logic [AW-1:0] rsp_addr;
    logic          overrun;

    burst_read_responder #(
        .DW(DW), .AW(AW), .BLOCK_BYTES(BLK), .MEM_WORDS(WORDS), .LAT(LAT)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .mst_sync(mst_sync), .mst_data(mst_data), .rsp_sync(rsp_sync),
        .rsp_data(rsp_data), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
        .overrun(overrun)
    );

    always #2 clk = ~clk;

    int nchk = 0;
    int nerr = 0;
    int cyc = 0;
    int stray = 0;
    int beats_seen = 0;
    bit prev_sync = 1'b0;
    bit prev_ready = 1'b0;
    bit finished = 1'b0;

    logic [DW-1:0] mdl [WORDS];
    logic [DW-1:0] exp_data [$];
    logic [AW-1:0] exp_addr [$];
    int            exp_first [$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < WORDS; i++) mdl[i] = DW'(i);
    endtask

    // Monitor: pops the scoreboard as beats and completions appear.
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_sync  <= 1'b0;
            prev_ready <= 1'b0;
            beats_seen <= 0;
        end else begin
            if (rsp_sync) begin
                if (!prev_sync && exp_first.size() > 0) begin
                    chk(cyc == exp_first[0], "R3 first beat cycle", cyc, exp_first[0]);
                    void'(exp_first.pop_front());
                end
                if (exp_data.size() == 0) begin
                    stray <= stray + 1;
                    chk(1'b0, "R9 stray beat", rsp_data, 0);
                end else begin
                    chk(rsp_data == exp_data[0], "R4 beat data", rsp_data, exp_data[0]);
                    void'(exp_data.pop_front());
                end
                beats_seen <= beats_seen + 1;
            end
            if (rsp_ready) begin
                chk(!rsp_sync && prev_sync, "R5 ready after sync", {rsp_sync, prev_sync}, 32'h1);
                chk(beats_seen == BEATS, "R4 burst length", beats_seen, BEATS);
                chk(rsp_data == '0, "R4 data zero at ready", rsp_data, 0);
                if (exp_addr.size() == 0) begin
                    chk(1'b0, "R9 unexpected ready", rsp_addr, 0);
                end else begin
                    chk(rsp_addr == exp_addr[0], "R5 echoed address", rsp_addr, exp_addr[0]);
                    void'(exp_addr.pop_front());
                end
                beats_seen <= 0;
            end
            if (prev_ready) begin
                chk(!rsp_ready && rsp_addr == '0, "R5 ready single cycle, echo zero", rsp_addr, 0);
            end
            prev_sync  <= rsp_sync;
            prev_ready <= rsp_ready;
        end
    end

    // Driver: issues a request, loads the expected beats, optionally writes.
    task automatic do_req(input logic [AW-1:0] a, input bit wr, input logic [DW-1:0] seed, input bit wait_done);
        int base;
        int c0;
        base = int'(a >> 2) % WORDS;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        c0 = cyc;
        for (int k = 0; k < BEATS; k++) exp_data.push_back(mdl[(base + k) % WORDS]);
        exp_addr.push_back(a);
        exp_first.push_back(c0 + LAT + 1);
        @(negedge clk);
        req_valid = 1'b0;
        req_addr  = '0;
        if (wr) begin
            repeat (LAT) @(negedge clk);
            for (int k = 0; k < BEATS; k++) begin
                mst_sync = 1'b1;
                mst_data = seed ^ DW'(k);
                mdl[(base + k) % WORDS] = seed ^ DW'(k);
                @(negedge clk);
            end
            mst_sync = 1'b0;
            mst_data = '0;
        end
        if (wait_done) begin
            for (int w = 0; w < BEATS + LAT + 20 && exp_addr.size() != 0; w++) @(negedge clk);
            chk(exp_addr.size() == 0, "R5 completion seen", exp_addr.size(), 0);
            @(negedge clk);
        end
    endtask

    task automatic check_reset_state();
        chk(!rsp_sync && !rsp_ready, "R1 strobes low", {rsp_sync, rsp_ready}, 0);
        chk(rsp_data == '0, "R1 data zero", rsp_data, 0);
        chk(rsp_addr == '0, "R1 echo zero", rsp_addr, 0);
        chk(!overrun, "R1 overrun clear", overrun, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        check_reset_state();                         // R1 during reset
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state();                         // R1 after release

        do_req(32'h0000_0000, 1'b0, '0, 1'b1);       // R2 R3 R4 R6 basic read
        do_req(32'h0000_0803, 1'b0, '0, 1'b1);       // R10 low bits ignored
        do_req(32'h0000_0C00, 1'b0, '0, 1'b1);       // R7 wraps past top word
        do_req(32'h0000_0400, 1'b1, 32'hA5A5_0000, 1'b1); // R8 read-first store
        do_req(32'h0000_0400, 1'b0, '0, 1'b1);       // R8 read back stored words

        // R9: request during a burst
        do_req(32'h0000_0000, 1'b0, '0, 1'b0);
        repeat (100) @(negedge clk);
        chk(!overrun, "R9 overrun clear before", overrun, 0);
        req_valid = 1'b1;
        req_addr  = 32'h0000_0800;
        @(negedge clk);
        req_valid = 1'b0;
        req_addr  = '0;
        chk(overrun, "R9 overrun set", overrun, 1);
        repeat (BEATS + 2 * LAT + 20) @(negedge clk);
        chk(exp_addr.size() == 0, "R9 original burst completed", exp_addr.size(), 0);
        chk(stray == 0, "R9 no extra burst", stray, 0);
        do_req(32'h0000_0200, 1'b0, '0, 1'b1);
        chk(overrun, "R9 overrun sticky", overrun, 1);

        // R6: reset mid-burst restores the memory image
        do_req(32'h0000_0400, 1'b0, '0, 1'b0);
        repeat (50) @(negedge clk);
        rst_n = 1'b0;
        exp_data.delete();
        exp_addr.delete();
        exp_first.delete();
        repeat (2) @(negedge clk);
        check_reset_state();
        model_reset();
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state();
        do_req(32'h0000_0400, 1'b0, '0, 1'b1);       // R6 index pattern again
        chk(stray == 0, "R9 no stray beats overall", stray, 0);

        finished = 1'b1;
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule